// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the operand address for an 8-bit processor once the opcode and its operand bytes have been fetched. The decoder hands it an addressing mode, the one or two operand bytes, the X and Y index registers and the program counter value that points at the next instruction. A one-cycle `start` pulse launches the computation. Direct modes finish in a single cycle. Indirect modes read a two-byte pointer through a synchronous read port and finish a few cycles later. `done` pulses once when the outputs are valid.

Zero-page indexing and every pointer fetch from page zero wrap within page zero. Pointer fetches from a full 16-bit address carry into the next page. The bit-test-and-branch mode has two results: a zero-page data address and a separate branch target. A page-crossed flag reports when an index addition changes the high address byte, so the sequencer can add its extra cycle.

Top module: `effective_addr_gen`

## Requirements
- R1: Reset state. While `rst` is high and after it falls, `done`, `mem_re` and `page_crossed` are 0, and `eff_addr` and `br_target` are 0x0000.
- R2: `mode` encoding and start behaviour. The codes are 0 implied, 1 accumulator, 2 immediate, 3 zp, 4 zp+X, 5 zp+Y, 6 abs, 7 abs+X, 8 abs+Y, 9 relative, 10 zp-plus-relative, 11 (zp), 12 (zp,X), 13 (zp),Y, 14 (abs), 15 (abs,X). An accepted start in modes 0 to 10 raises `done` on the first clock edge after it. In modes 11 to 15 `done` rises on the fourth edge. `done` is high for exactly one cycle.
- R3: Implied and accumulator modes give 0x0000. Immediate gives `next_pc` - 1, which is the address of the operand byte.
- R4: Zero-page mode gives {0x00, opnd_lo}. Zero-page indexed modes give {0x00, (opnd_lo + index) mod 256}.
- R5: Absolute gives {opnd_hi, opnd_lo}. Absolute indexed adds X or Y over the full 16 bits. `page_crossed` is 1 only when an abs+X, abs+Y or (zp),Y addition changes the high byte, and 0 in every other mode.
- R6: Relative mode gives `next_pc` plus `opnd_lo` read as a signed two's-complement offset.
- R7: Zero-page-plus-relative mode gives `eff_addr` = {0x00, opnd_lo} and `br_target` = `next_pc` + sign-extended `opnd_hi`. In every other mode `br_target` is 0x0000.
- R8: (zp) and (zp,X) read the pointer low byte at P = opnd_lo (plus X modulo 256 for (zp,X)) and the high byte at (P + 1) mod 256 in page zero. The pointer is the result.
- R9: (zp),Y reads its pointer the same way from opnd_lo, then adds Y over 16 bits.
- R10: (abs) and (abs,X) read the pointer from A and A + 1 with a full 16-bit increment, where A = {opnd_hi, opnd_lo} (+ X for (abs,X)).
- R11: An indirect operation asserts `mem_re` on exactly two consecutive cycles, low-byte address first. Read data is taken one cycle after the address it answers.
- R12: A `start` that arrives while an indirect operation is in progress is ignored. All outputs hold their values until the next accepted start completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; mode and operands are sampled with it |
| mode | input | 4 | Addressing mode code (see R2) |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| next_pc | input | 16 | Address of the byte after the instruction |
| mem_re | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| done | output | 1 | One-cycle result-valid pulse |
| eff_addr | output | 16 | Effective address |
| br_target | output | 16 | Branch target for zero-page-plus-relative mode |
| page_crossed | output | 1 | Index addition changed the high address byte |

## Verification
Direct modes are due at the first edge after the start edge. Indirect modes are due at the fourth edge, after two read cycles and one edge to capture the high byte. Every scenario counts falling edges from the start pulse, checks that `done` first appears at exactly that count, and checks one edge later that `done` has dropped and the results have held. The bench memory returns a value computed from the address. The expected pointers, including those at wrap points such as 0x00FF/0x0000 and 0x12FF/0x1300, are therefore derived in the bench from the address rules alone.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_IMPL    = 4'd0,
        AM_ACC     = 4'd1,
        AM_IMM     = 4'd2,
        AM_ZP      = 4'd3,
        AM_ZPX     = 4'd4,
        AM_ZPY     = 4'd5,
        AM_ABS     = 4'd6,
        AM_ABSX    = 4'd7,
        AM_ABSY    = 4'd8,
        AM_REL     = 4'd9,
        AM_ZPREL   = 4'd10,
        AM_ZPIND   = 4'd11,
        AM_ZPXIND  = 4'd12,
        AM_ZPINDY  = 4'd13,
        AM_ABSIND  = 4'd14,
        AM_ABSXIND = 4'd15
    } am_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] target;
        logic              crossed;
    } ea_res_t;

    function automatic logic [ADDR_W-1:0] rel_add(logic [ADDR_W-1:0] base,
                                                  logic [DATA_W-1:0] off);
        return base + {{(ADDR_W-DATA_W){off[DATA_W-1]}}, off};
    endfunction

    function automatic logic needs_ptr(am_e m);
        return m inside {AM_ZPIND, AM_ZPXIND, AM_ZPINDY, AM_ABSIND, AM_ABSXIND};
    endfunction

    function automatic logic ptr_in_zp(am_e m);
        return m inside {AM_ZPIND, AM_ZPXIND, AM_ZPINDY};
    endfunction

endpackage

// File: rtl/eag_direct_calc.sv
module eag_direct_calc
    import eag_pkg::*;
(
    input  am_e                 mode,
    input  logic [DATA_W-1:0]   lo,
    input  logic [DATA_W-1:0]   hi,
    input  logic [DATA_W-1:0]   x,
    input  logic [DATA_W-1:0]   y,
    input  logic [ADDR_W-1:0]   pc,
    output ea_res_t             res,
    output logic [ADDR_W-1:0]   ptr_addr
);
    localparam int PAD = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] base_x;
    logic [ADDR_W-1:0] base_y;
    logic [DATA_W-1:0] zp_x;
    logic [DATA_W-1:0] zp_y;

    always_comb begin
        base   = {hi, lo};
        base_x = base + {{PAD{1'b0}}, x};
        base_y = base + {{PAD{1'b0}}, y};
        zp_x   = lo + x;
        zp_y   = lo + y;

        res      = '0;
        ptr_addr = '0;
        unique case (mode)
            AM_IMPL, AM_ACC: res.addr = '0;
            AM_IMM:          res.addr = pc - 1'b1;
            AM_ZP:           res.addr = {{PAD{1'b0}}, lo};
            AM_ZPX:          res.addr = {{PAD{1'b0}}, zp_x};
            AM_ZPY:          res.addr = {{PAD{1'b0}}, zp_y};
            AM_ABS:          res.addr = base;
            AM_ABSX: begin
                res.addr    = base_x;
                res.crossed = base_x[ADDR_W-1:DATA_W] != hi;
            end
            AM_ABSY: begin
                res.addr    = base_y;
                res.crossed = base_y[ADDR_W-1:DATA_W] != hi;
            end
            AM_REL:          res.addr = rel_add(pc, lo);
            AM_ZPREL: begin
                res.addr   = {{PAD{1'b0}}, lo};
                res.target = rel_add(pc, hi);
            end
            AM_ZPIND, AM_ZPINDY: ptr_addr = {{PAD{1'b0}}, lo};
            AM_ZPXIND:           ptr_addr = {{PAD{1'b0}}, zp_x};
            AM_ABSIND:           ptr_addr = base;
            AM_ABSXIND:          ptr_addr = base_x;
            default:             res = '0;
        endcase
    end

endmodule

// File: rtl/eag_ptr_seq.sv
module eag_ptr_seq
    import eag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  logic [ADDR_W-1:0]   ptr_addr,
    input  logic                zp_wrap,
    output logic                mem_re,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                ptr_valid,
    output logic [ADDR_W-1:0]   ptr_val
);
    typedef enum logic [1:0] {S_IDLE, S_RD_LO, S_RD_HI, S_FIN} seq_e;

    seq_e              state;
    logic [ADDR_W-1:0] pa_q;
    logic              wrap_q;
    logic [DATA_W-1:0] lo_q;
    logic [ADDR_W-1:0] pa_next;

    always_comb begin
        if (wrap_q)
            pa_next = {{(ADDR_W-DATA_W){1'b0}}, pa_q[DATA_W-1:0] + 1'b1};
        else
            pa_next = pa_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            pa_q   <= '0;
            wrap_q <= 1'b0;
            lo_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (launch) begin
                    state  <= S_RD_LO;
                    pa_q   <= ptr_addr;
                    wrap_q <= zp_wrap;
                end
                S_RD_LO: state <= S_RD_HI;
                S_RD_HI: begin
                    lo_q  <= mem_rdata;
                    state <= S_FIN;
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign mem_re    = (state == S_RD_LO) || (state == S_RD_HI);
    assign mem_addr  = (state == S_RD_HI) ? pa_next : (state == S_RD_LO) ? pa_q : '0;
    assign busy      = state != S_IDLE;
    assign ptr_valid = state == S_FIN;
    assign ptr_val   = {mem_rdata, lo_q};

    // R8
    ptr_zero_page_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && wrap_q) |-> (mem_addr[ADDR_W-1:DATA_W] == '0));

    // R11
    read_second_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_re) |=> mem_re);

    // R11
    read_pair_end_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && $past(mem_re)) |=> !mem_re);

endmodule

// File: rtl/effective_addr_gen.sv
module effective_addr_gen
    import eag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MODE_W-1:0]   mode,
    input  logic [DATA_W-1:0]   opnd_lo,
    input  logic [DATA_W-1:0]   opnd_hi,
    input  logic [DATA_W-1:0]   idx_x,
    input  logic [DATA_W-1:0]   idx_y,
    input  logic [ADDR_W-1:0]   next_pc,
    output logic                mem_re,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                done,
    output logic [ADDR_W-1:0]   eff_addr,
    output logic [ADDR_W-1:0]   br_target,
    output logic                page_crossed
);
    localparam int PAD = ADDR_W - DATA_W;

    am_e               mode_in;
    ea_res_t           dres;
    logic [ADDR_W-1:0] dptr;
    logic              seq_busy;
    logic              ptr_valid;
    logic [ADDR_W-1:0] ptr_val;
    logic              accept;
    logic              launch;

    am_e               mode_q;
    logic [DATA_W-1:0] y_q;
    ea_res_t           res_q;
    logic              done_q;
    ea_res_t           ind_res;
    logic [ADDR_W-1:0] post_sum;

    assign mode_in = am_e'(mode);
    assign accept  = start && !seq_busy;
    assign launch  = accept && needs_ptr(mode_in);

    eag_direct_calc u_direct (
        .mode     (mode_in),
        .lo       (opnd_lo),
        .hi       (opnd_hi),
        .x        (idx_x),
        .y        (idx_y),
        .pc       (next_pc),
        .res      (dres),
        .ptr_addr (dptr)
    );

    eag_ptr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .ptr_addr  (dptr),
        .zp_wrap   (ptr_in_zp(mode_in)),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .busy      (seq_busy),
        .ptr_valid (ptr_valid),
        .ptr_val   (ptr_val)
    );

    always_comb begin
        post_sum = ptr_val + {{PAD{1'b0}}, y_q};
        ind_res  = '0;
        if (mode_q == AM_ZPINDY) begin
            ind_res.addr    = post_sum;
            ind_res.crossed = post_sum[ADDR_W-1:DATA_W] != ptr_val[ADDR_W-1:DATA_W];
        end else begin
            ind_res.addr = ptr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= AM_IMPL;
            y_q    <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                mode_q <= mode_in;
                y_q    <= idx_y;
                if (!needs_ptr(mode_in)) begin
                    res_q  <= dres;
                    done_q <= 1'b1;
                end
            end
            if (ptr_valid) begin
                res_q  <= ind_res;
                done_q <= 1'b1;
            end
        end
    end

    assign done         = done_q;
    assign eff_addr     = res_q.addr;
    assign br_target    = res_q.target;
    assign page_crossed = res_q.crossed;

    // R2
    direct_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !seq_busy && !needs_ptr(mode_in)) |=> done);

    // R3
    implied_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q == AM_IMPL || mode_q == AM_ACC)) |-> (eff_addr == '0));

    // R4
    zp_page_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q inside {AM_ZP, AM_ZPX, AM_ZPY, AM_ZPREL}))
            |-> (eff_addr[ADDR_W-1:DATA_W] == '0));

    // R5
    crossed_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (done && page_crossed) |-> (mode_q inside {AM_ABSX, AM_ABSY, AM_ZPINDY}));

    // R7
    target_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q != AM_ZPREL) |-> (br_target == '0));

    // R12
    no_done_mid_read_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && $past(mem_re)) |-> !done);

endmodule

// File: tb/effective_addr_gen_bench.sv
module effective_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  mode;
    logic [7:0]  opnd_lo, opnd_hi, idx_x, idx_y;
    logic [15:0] next_pc;
    logic        mem_re;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [15:0] eff_addr, br_target;
    logic        page_crossed;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    effective_addr_gen u_effective_addr_gen (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
        .next_pc(next_pc), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .eff_addr(eff_addr),
        .br_target(br_target), .page_crossed(page_crossed)
    );

    function automatic logic [7:0] mf(logic [15:0] a);
        return (a[7:0] ^ 8'hA5) + a[15:8];
    endfunction

    always_ff @(posedge clk) begin
        if (mem_re) mem_rdata <= mf(mem_addr);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one operation and check latency, results, pulse width and hold.
    task automatic run_op(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc,
                          input logic [15:0] exp_a, input logic [15:0] exp_t,
                          input logic exp_c, input int lat, input string tag);
        int n;
        @(negedge clk);
        mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; next_pc = pc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk(n == lat, {tag, " R2 latency"}, n, lat);
        chk(eff_addr == exp_a, {tag, " eff_addr"}, eff_addr, exp_a);
        chk(br_target == exp_t, {tag, " br_target R7"}, br_target, exp_t);
        chk(page_crossed == exp_c, {tag, " page_crossed R5"}, page_crossed, exp_c);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R2 single pulse"}, done, 0);
        chk(eff_addr == exp_a, {tag, " R12 hold"}, eff_addr, exp_a);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; mode = '0; opnd_lo = '0; opnd_hi = '0;
        idx_x = '0; idx_y = '0; next_pc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && mem_re == 0 && page_crossed == 0, "R1 flags", {done, mem_re, page_crossed}, 0);
        chk(eff_addr == 0 && br_target == 0, "R1 addresses", eff_addr, 0);
    endtask

    task automatic t_simple();
        run_op(4'd0, 8'h12, 8'h34, 8'h01, 8'h02, 16'h4000, 16'h0000, 16'h0, 1'b0, 1, "R3 implied");
        run_op(4'd1, 8'hFF, 8'hFF, 8'h01, 8'h02, 16'h4000, 16'h0000, 16'h0, 1'b0, 1, "R3 accum");
        run_op(4'd2, 8'h99, 8'h00, 8'h00, 8'h00, 16'h1235, 16'h1234, 16'h0, 1'b0, 1, "R3 immediate");
    endtask

    task automatic t_zero_page();
        run_op(4'd3, 8'h44, 8'h77, 8'h10, 8'h10, 16'h8000, 16'h0044, 16'h0, 1'b0, 1, "R4 zp");
        run_op(4'd4, 8'hF0, 8'h77, 8'h20, 8'h00, 16'h8000, 16'h0010, 16'h0, 1'b0, 1, "R4 zpx wrap");
        run_op(4'd5, 8'h81, 8'h77, 8'h00, 8'hFF, 16'h8000, 16'h0080, 16'h0, 1'b0, 1, "R4 zpy wrap");
    endtask

    task automatic t_absolute();
        run_op(4'd6, 8'hCD, 8'hAB, 8'h50, 8'h50, 16'h0, 16'hABCD, 16'h0, 1'b0, 1, "R5 abs");
        run_op(4'd7, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 16'h1310, 16'h0, 1'b1, 1, "R5 absx cross");
        run_op(4'd7, 8'h00, 8'h12, 8'h05, 8'h00, 16'h0, 16'h1205, 16'h0, 1'b0, 1, "R5 absx same page");
        run_op(4'd8, 8'hFF, 8'hFF, 8'h00, 8'h01, 16'h0, 16'h0000, 16'h0, 1'b1, 1, "R5 absy wrap 64K");
    endtask

    task automatic t_relative();
        run_op(4'd9, 8'h80, 8'h00, 8'h00, 8'h00, 16'h2000, 16'h1F80, 16'h0, 1'b0, 1, "R6 rel back");
        run_op(4'd9, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h2000, 16'h207F, 16'h0, 1'b0, 1, "R6 rel fwd");
        run_op(4'd10, 8'h44, 8'hFE, 8'h00, 8'h00, 16'h3003, 16'h0044, 16'h3001, 1'b0, 1, "R7 zprel");
    endtask

    task automatic t_zp_pointers();
        logic [15:0] p;
        p = {mf(16'h0000), mf(16'h00FF)};
        run_op(4'd11, 8'hFF, 8'h00, 8'h00, 8'h00, 16'h0, p, 16'h0, 1'b0, 4, "R8 zpind wrap");
        p = {mf(16'h0001), mf(16'h0000)};
        run_op(4'd12, 8'hF8, 8'h00, 8'h08, 8'h00, 16'h0, p, 16'h0, 1'b0, 4, "R8 zpxind index wrap");
        p = {mf(16'h0000), mf(16'h00FF)};
        run_op(4'd12, 8'h80, 8'h00, 8'h7F, 8'h00, 16'h0, p, 16'h0, 1'b0, 4, "R8 zpxind ptr wrap");
        p = {mf(16'h0011), mf(16'h0010)};
        run_op(4'd13, 8'h10, 8'h00, 8'h00, 8'h60, 16'h0, p + 16'h0060, 16'h0, 1'b1, 4, "R9 zpindy cross");
        run_op(4'd13, 8'h10, 8'h00, 8'h00, 8'h01, 16'h0, p + 16'h0001, 16'h0, 1'b0, 4, "R9 zpindy same");
        p = {mf(16'h0000), mf(16'h00FF)};
        run_op(4'd13, 8'hFF, 8'h00, 8'h00, 8'h02, 16'h0, p + 16'h0002, 16'h0, 1'b0, 4, "R9 zpindy ptr wrap");
    endtask

    task automatic t_abs_pointers();
        logic [15:0] p;
        p = {mf(16'h1300), mf(16'h12FF)};
        run_op(4'd14, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0, p, 16'h0, 1'b0, 4, "R10 absind no page wrap");
        p = {mf(16'h2100), mf(16'h20FF)};
        run_op(4'd15, 8'hFE, 8'h20, 8'h01, 8'h00, 16'h0, p, 16'h0, 1'b0, 4, "R10 absxind");
    endtask

    task automatic t_read_port();
        int reads = 0;
        logic [15:0] first_a, second_a;
        @(negedge clk);
        mode = 4'd14; opnd_lo = 8'h34; opnd_hi = 8'h56; start = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (mem_re) begin
                if (reads == 0) first_a = mem_addr; else second_a = mem_addr;
                reads++;
            end
        end
        chk(reads == 2, "R11 read count", reads, 2);
        chk(first_a == 16'h5634 && second_a == 16'h5635, "R11 read order", {first_a, second_a}, 32'h56345635);
    endtask

    task automatic t_busy_ignore();
        int dones = 0;
        logic [15:0] p;
        p = {mf(16'h4001), mf(16'h4000)};
        @(negedge clk);
        mode = 4'd14; opnd_lo = 8'h00; opnd_hi = 8'h40; start = 1'b1;
        @(negedge clk);
        mode = 4'd6; opnd_lo = 8'h34; opnd_hi = 8'h12;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (done) begin
                dones++;
                chk(eff_addr == p, "R12 busy start ignored value", eff_addr, p);
            end
            @(negedge clk);
        end
        chk(dones == 1, "R12 one completion", dones, 1);
        chk(eff_addr == p, "R12 result held", eff_addr, p);
    endtask

    initial begin
        t_reset();
        t_simple();
        t_zero_page();
        t_absolute();
        t_relative();
        t_zp_pointers();
        t_abs_pointers();
        t_read_port();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule